// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block derives two timing strobes from the system clock for a serial port. A first counter divides the clock by n+1, where n is a divisor that a host writes as two byte-wide halves. Each time that counter expires it raises an oversampling strobe, which the receiver uses. A second counter then divides those strobes by 4, 16 or 64 to produce the bit-rate strobe that paces the transmitter. The ratio of 4, 16 or 64 comes from three mode inputs: a synchronous-mode flag, a high-speed flag and a wide-divisor flag.

The divisor is either 8 bits wide, taken from the low half only, or 16 bits wide, taken from both halves. A write to either half restarts both counters at once, so the first strobes after a write come exactly one full period after it. Each strobe is one clock wide.

Top module: `baud_gen`

## Requirements
- R1: While the mode and divisor are unchanged, `os_tick` is high for one cycle in every n+1 cycles, where n is the effective divisor.
- R2: With `wide_mode` low, n equals the low byte and the high byte has no effect on either strobe.
- R3: With `wide_mode` high, n equals {high byte, low byte}, with the high byte in the upper 8 bits.
- R4: With `sync_mode` high, the bit ratio is 4 `os_tick` periods, whatever `hs_mode` and `wide_mode` are.
- R5: With `sync_mode` low and both `hs_mode` and `wide_mode` high, the bit ratio is 4.
- R6: With `sync_mode` low and exactly one of `hs_mode` and `wide_mode` high, the bit ratio is 16.
- R7: With `sync_mode` low and both `hs_mode` and `wide_mode` low, the bit ratio is 64.
- R8: A write (`wr_lo` or `wr_hi` high at a clock edge) restarts counting. Counting the cycle right after that edge as cycle 1, the first `os_tick` is in cycle n+1 and the first `bit_tick` is in cycle M*(n+1), where M is the bit ratio.
- R9: `bit_tick` lasts one cycle, always coincides with an `os_tick`, and recurs every M*(n+1) cycles.
- R10: Reset clears both divisor bytes and both counters, and holds both strobes low. After reset the divisor is 0, so `os_tick` is high in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 1 | Synchronous-mode flag; forces a ratio of 4 |
| hs_mode | input | 1 | High-speed flag |
| wide_mode | input | 1 | Selects the 16-bit divisor |
| wr_lo | input | 1 | Write strobe for the low divisor byte |
| wr_hi | input | 1 | Write strobe for the high divisor byte |
| wr_data | input | 8 | Byte written by `wr_lo` or `wr_hi` |
| os_tick | output | 1 | Oversampling strobe, every n+1 cycles |
| bit_tick | output | 1 | Bit-rate strobe, every M*(n+1) cycles |

## Verification
The checker tests the following on every cycle:
- the spacing of the oversampling strobe against the live divisor;
- the number of oversampling strobes between bit strobes against the decoded ratio;
- the one-cycle width of `bit_tick` and its overlap with `os_tick`;
- quiet outputs during reset;
- that no bit strobe follows directly after a write.

The checker drops its spacing checks after a mode change in the middle of a count. Only the bench scenarios show the rest:
- the exact delay from a write to the first strobes;
- that the high byte is ignored in 8-bit mode;
- that a write in the middle of a count truly restarts it;
- each of the mode decodes.

// File: rtl/baud_pkg.sv
package baud_pkg;

    typedef enum logic [1:0] {
        RATIO_X4  = 2'd0,
        RATIO_X16 = 2'd1,
        RATIO_X64 = 2'd2
    } ratio_e;

    localparam int PRE_W = 6;

    typedef struct packed {
        logic sync_mode;
        logic hs_mode;
        logic wide_mode;
    } mode_t;

    function automatic ratio_e decode_ratio(input mode_t m);
        if (m.sync_mode)                 return RATIO_X4;
        else if (m.hs_mode && m.wide_mode) return RATIO_X4;
        else if (m.hs_mode || m.wide_mode) return RATIO_X16;
        else                             return RATIO_X64;
    endfunction

    function automatic logic [PRE_W-1:0] ratio_last(input ratio_e r);
        case (r)
            RATIO_X4:  return PRE_W'(3);
            RATIO_X16: return PRE_W'(15);
            default:   return PRE_W'(63);
        endcase
    endfunction

endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
    parameter int REG_W = 8,
    localparam int DIV_W = 2 * REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wide_mode,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [REG_W-1:0] wr_data,
    output logic [DIV_W-1:0] divisor,
    output logic [DIV_W-1:0] load_val,
    output logic             reload
);
    logic [REG_W-1:0] lo_q, hi_q, lo_n, hi_n;

    always_comb begin
        lo_n = wr_lo ? wr_data : lo_q;
        hi_n = wr_hi ? wr_data : hi_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

    // effective divisor now, and the value in force after this edge's write
    assign divisor  = wide_mode ? {hi_q, lo_q} : {{REG_W{1'b0}}, lo_q};
    assign load_val = wide_mode ? {hi_n, lo_n} : {{REG_W{1'b0}}, lo_n};
    assign reload   = wr_lo | wr_hi;
endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic [DIV_W-1:0] load_val,
    input  logic [DIV_W-1:0] divisor,
    output logic             os_tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             expire;

    assign expire  = (cnt_q == '0);
    assign os_tick = expire & ~rst;

    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= '0;
        else if (reload)  cnt_q <= load_val;
        else if (expire)  cnt_q <= divisor;
        else              cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale
    import baud_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   reload,
    input  ratio_e ratio,
    input  logic   os_tick,
    output logic   bit_tick
);
    logic [PRE_W-1:0] pre_q;
    logic             at_last;

    assign at_last  = (pre_q >= ratio_last(ratio));
    assign bit_tick = os_tick & at_last;

    always_ff @(posedge clk) begin
        if (rst)          pre_q <= '0;
        else if (reload)  pre_q <= '0;
        else if (os_tick) pre_q <= at_last ? '0 : pre_q + 1'b1;
    end
endmodule

// File: rtl/baud_gen.sv
module baud_gen
    import baud_pkg::*;
#(
    parameter int REG_W = 8,
    localparam int DIV_W = 2 * REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_mode,
    input  logic             hs_mode,
    input  logic             wide_mode,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [REG_W-1:0] wr_data,
    output logic             os_tick,
    output logic             bit_tick
);
    logic [DIV_W-1:0] divisor, load_val;
    logic             reload;
    mode_t            mode;
    ratio_e           ratio;

    assign mode  = '{sync_mode: sync_mode, hs_mode: hs_mode, wide_mode: wide_mode};
    assign ratio = decode_ratio(mode);

    baud_div_regs #(.REG_W(REG_W)) u_regs (
        .clk(clk), .rst(rst), .wide_mode(wide_mode),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .divisor(divisor), .load_val(load_val), .reload(reload)
    );

    baud_div_counter #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .reload(reload),
        .load_val(load_val), .divisor(divisor), .os_tick(os_tick)
    );

    baud_prescale u_pre (
        .clk(clk), .rst(rst), .reload(reload),
        .ratio(ratio), .os_tick(os_tick), .bit_tick(bit_tick)
    );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             sync_mode,
    input logic             hs_mode,
    input logic             wide_mode,
    input logic             wr_lo,
    input logic             wr_hi,
    input logic [DIV_W-1:0] divisor,
    input logic             os_tick,
    input logic             bit_tick
);
    logic [DIV_W:0] gap_q;
    logic           gap_ok_q, run_ok_q;
    logic [6:0]     os_seen_q;
    logic           wide_q;
    logic [2:0]     mode_q;
    logic [6:0]     ratio_n;
    logic           wr;

    assign wr = wr_lo | wr_hi;

    // ratio computed here from the table directly
    always_comb begin
        if (sync_mode || (hs_mode && wide_mode)) ratio_n = 7'd4;
        else if (hs_mode ^ wide_mode)            ratio_n = 7'd16;
        else                                     ratio_n = 7'd64;
    end

    always_ff @(posedge clk) begin
        wide_q <= wide_mode;
        mode_q <= {sync_mode, hs_mode, wide_mode};
        if (rst) begin
            gap_q     <= 1;
            gap_ok_q  <= 1'b1;
            os_seen_q <= '0;
            run_ok_q  <= 1'b1;
        end else begin
            if (wr || os_tick) begin
                gap_q    <= 1;
                gap_ok_q <= 1'b1;
            end else begin
                gap_q <= gap_q + 1'b1;
                if (wide_mode != wide_q) gap_ok_q <= 1'b0;
            end
            if (wr || bit_tick) begin
                os_seen_q <= '0;
                run_ok_q  <= 1'b1;
            end else begin
                if (os_tick) os_seen_q <= os_seen_q + 1'b1;
                if ({sync_mode, hs_mode, wide_mode} != mode_q) run_ok_q <= 1'b0;
            end
        end
    end

    AST_OS_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (os_tick && gap_ok_q && (wide_mode == wide_q)) |-> (gap_q == {1'b0, divisor} + 1'b1)); // R1

    AST_BIT_RATIO: assert property (@(posedge clk) disable iff (rst)
        (bit_tick && run_ok_q && ({sync_mode, hs_mode, wide_mode} == mode_q))
            |-> (os_seen_q + 7'd1 == ratio_n)); // R4

    AST_BIT_WITH_OS: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> os_tick); // R9

    AST_BIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> !bit_tick); // R9

    AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (rst)
        wr |=> !bit_tick); // R8

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |-> (!os_tick && !bit_tick)); // R10
endmodule

bind baud_gen baud_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst(rst), .sync_mode(sync_mode), .hs_mode(hs_mode),
    .wide_mode(wide_mode), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .divisor(divisor), .os_tick(os_tick), .bit_tick(bit_tick)
);

// File: tb/sim_baud_gen.sv
`timescale 1ns/1ps
module sim_baud_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_mode = 1'b0, hs_mode = 1'b0, wide_mode = 1'b0;
    logic       wr_lo = 1'b0, wr_hi = 1'b0;
    logic [7:0] wr_data = '0;
    logic       os_tick, bit_tick;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    baud_gen u0 (
        .clk(clk), .rst(rst), .sync_mode(sync_mode), .hs_mode(hs_mode),
        .wide_mode(wide_mode), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wr_data(wr_data), .os_tick(os_tick), .bit_tick(bit_tick)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ratio_of(input bit s, input bit h, input bit w);
        if (s) return 4;
        if (h && w) return 4;
        if (h || w) return 16;
        return 64;
    endfunction

    task automatic write_byte(input bit hi, input logic [7:0] d);
        @(negedge clk);
        wr_data = d;
        wr_lo = !hi;
        wr_hi = hi;
        @(negedge clk);
        wr_lo = 1'b0;
        wr_hi = 1'b0;
    endtask

    // sets mode, writes high then low byte, measures from the low write
    task automatic run_case(input string req, input bit s, input bit h, input bit w,
                            input logic [7:0] hi, input logic [7:0] lo);
        int n, m, ebit, idx, fo, fb, g;
        n    = w ? {hi, lo} : int'(lo);
        m    = ratio_of(s, h, w);
        ebit = m * (n + 1);
        @(negedge clk);
        sync_mode = s; hs_mode = h; wide_mode = w;
        write_byte(1'b1, hi);
        write_byte(1'b0, lo);
        idx = 1; fo = 0; fb = 0;
        while (fb == 0 && idx <= 20000) begin
            if (os_tick && fo == 0) fo = idx;
            if (bit_tick) fb = idx;
            else begin
                @(negedge clk);
                idx++;
            end
        end
        check({req, " R1 R8"}, "first os_tick cycle", fo, n + 1);
        check({req, " R8"}, "first bit_tick cycle", fb, ebit);
        check("R9", "os_tick with bit_tick", int'(os_tick), 1);
        @(negedge clk);
        check("R9", "bit_tick width", int'(bit_tick), 0);
        g = 1;
        while (!bit_tick && g <= 20000) begin
            @(negedge clk);
            g++;
        end
        check({req, " R9"}, "bit_tick period", g, ebit);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        check("R10", "os_tick in reset", int'(os_tick), 0);
        check("R10", "bit_tick in reset", int'(bit_tick), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R10", "os_tick after reset with divisor 0", int'(os_tick), 1);
    endtask

    task automatic test_restart();
        int idx;
        @(negedge clk);
        sync_mode = 1'b1; hs_mode = 1'b0; wide_mode = 1'b0;
        write_byte(1'b0, 8'd20);
        repeat (30) @(negedge clk);
        write_byte(1'b0, 8'd3);
        idx = 1;
        while (!bit_tick && idx <= 1000) begin
            @(negedge clk);
            idx++;
        end
        check("R8", "bit_tick after mid-count write", idx, 16);
    endtask

    initial begin
        test_reset();
        run_case("R7", 1'b0, 1'b0, 1'b0, 8'h00, 8'd3);   // x64, n=3
        run_case("R6", 1'b0, 1'b1, 1'b0, 8'h00, 8'd5);   // x16, hs only
        run_case("R3 R6", 1'b0, 1'b0, 1'b1, 8'h01, 8'd2);// x16, wide, n=258
        run_case("R3 R5", 1'b0, 1'b1, 1'b1, 8'h01, 8'd2);// x4, n=258
        run_case("R4", 1'b1, 1'b0, 1'b0, 8'h00, 8'd9);   // sync x4
        run_case("R4 R3", 1'b1, 1'b1, 1'b1, 8'h01, 8'd2);// sync x4 wide
        run_case("R2", 1'b0, 1'b1, 1'b0, 8'h55, 8'd7);   // high byte ignored
        run_case("R4 R1", 1'b1, 1'b0, 1'b0, 8'h00, 8'd0);// n=0
        test_restart();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule